// File: doc/BRIEF.md
# Instruction Group Boundary Commit Unit

This block sits in an in-order issue pipeline that hands it one decoded instruction slot per cycle. For every slot it decides whether that slot ends the current instruction group. Group-closing events are a stop marker, a taken branch, a break fault raised by the branch-unit break, and an illegal-operation fault from a reserved branch-space encoding. A reserved-if-predicate-true encoding closes the group only when its qualifying predicate is 1. Other break kinds, check instructions, return-from-interrupt and long branches do not end a group, and neither does any other interruption.

Register writes made inside a group are parked in a shadow buffer that has one pending bit per register. Until the group closes, both read ports keep returning the state from before the group, whichever instruction in the group made the write. On the slot that closes the group, every pending write is copied into the architectural file in one cycle, and the closing slot's own write goes with them. The next group therefore sees all of them. A small scratch memory is written straight through, so a later slot in the same group reads an earlier store. Two writes to one register in a single group raise a dependency-violation flag, and the later value wins.

Top module: `igroup_commit`

## Requirements
- R1: A valid slot with its stop marker set closes the group: `groupEnd` is 1 in that slot's cycle only.
- R2: A valid slot whose branch is taken closes the group.
- R3: A branch-unit break fault (`brkB`) or a reserved branch-space encoding fault (`rsvdB`) closes the group. A reserved-if-predicate encoding (`rsvdPredB`) closes it only when `predVal` is 1.
- R4: The other-break, check, return-from-interrupt and long-branch flags never close a group. A write pending at such a slot stays invisible to reads.
- R5: Within a group, `rdDataA` and `rdDataB` return the value from before the group, even for a register written by an earlier slot or by the same slot.
- R6: When a group closes, all pending writes, including the closing slot's own write, are visible to reads in the next cycle.
- R7: A second write to a register that already has a pending write in the same group drives `depViol` to 1 in that cycle. The later value is the one committed.
- R8: A scratch store (`memWrEn`) in one slot is returned by `memRdData` for the same address in any later slot, with no group boundary needed.
- R9: Synchronous active-high reset zeroes the register file and scratch memory and discards pending writes. The next valid slot starts a new group.
- R10: A slot with `slotValid` low has no effect: no group end, no register or memory write, no violation flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slotValid | input | 1 | Slot present this cycle |
| stopMark | input | 1 | Stop marker after this slot |
| brTaken | input | 1 | Branch in this slot is taken |
| brkB | input | 1 | Branch-unit break fault |
| rsvdB | input | 1 | Reserved branch-space encoding fault |
| rsvdPredB | input | 1 | Reserved-if-predicate-true branch encoding |
| predVal | input | 1 | Qualifying predicate of this slot |
| otherBrk | input | 1 | Non-branch-unit break |
| chkInst | input | 1 | Check instruction |
| rfiInst | input | 1 | Return from interrupt |
| brlInst | input | 1 | Long branch |
| wrEn | input | 1 | Register write request |
| wrIdx | input | 5 | Destination register |
| wrData | input | 64 | Write value |
| rdIdxA | input | 5 | Read port A index |
| rdIdxB | input | 5 | Read port B index |
| rdDataA | output | 64 | Read port A data |
| rdDataB | output | 64 | Read port B data |
| memWrEn | input | 1 | Scratch store |
| memWrAddr | input | 4 | Store word address |
| memWrData | input | 64 | Store data |
| memRdAddr | input | 4 | Load word address |
| memRdData | output | 64 | Load data |
| groupEnd | output | 1 | This slot closes the group |
| depViol | output | 1 | Repeated write in one group |

## Verification
The bench reads a register in the same slot that writes it, and again in later slots of the same group. A design that forwards buffered writes would return the new value too early. Each benign flag (other break, check, rfi, long branch) is driven with a write pending, which catches a design that commits on any control-flow event. The predicated reserved encoding is driven with its predicate at 0 and at 1. A double write followed by a stop exposes a design that keeps the first value or does not raise the flag. Invalid slots carrying a stop and writes, and a reset in the middle of a group, show whether stray commits or stale pending writes survive.

// File: rtl/igc_pkg.sv
package igc_pkg;
  parameter int NREG = 32;
  parameter int DW = 64;
  parameter int MWORDS = 16;
  localparam int IW = $clog2(NREG);
  localparam int AW = $clog2(MWORDS);

  typedef struct packed {
    logic            commit;
    logic            bufWr;
    logic [NREG-1:0] pendMask;
  } strobe_t;
endpackage

// File: rtl/igc_ctrl.sv
module igc_ctrl
  import igc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          slotValid,
  input  logic          stopMark,
  input  logic          brTaken,
  input  logic          brkB,
  input  logic          rsvdB,
  input  logic          rsvdPredB,
  input  logic          predVal,
  input  logic          otherBrk,
  input  logic          chkInst,
  input  logic          rfiInst,
  input  logic          brlInst,
  input  logic          wrEn,
  input  logic [IW-1:0] wrIdx,
  output strobe_t       st,
  output logic          groupEnd,
  output logic          depViol
);
  logic [NREG-1:0] pendMask;
  logic closeCause;
  logic benign;

  // only these events end a group
  assign closeCause = stopMark | brTaken | brkB | rsvdB | (rsvdPredB & predVal);
  assign benign     = otherBrk | chkInst | rfiInst | brlInst;
  assign groupEnd   = slotValid & closeCause;

  assign st.commit   = groupEnd;
  assign st.bufWr    = slotValid & wrEn;
  assign st.pendMask = pendMask;
  assign depViol     = slotValid & wrEn & pendMask[wrIdx];

  always_ff @(posedge clk) begin
    if (rst)
      pendMask <= '0;
    else if (groupEnd)
      pendMask <= '0;
    else if (slotValid && wrEn)
      pendMask[wrIdx] <= 1'b1;
  end

  p_clear_after_end_r6: assert property (@(posedge clk) disable iff (rst)
    groupEnd |=> (pendMask == '0));

  p_benign_no_close_r4: assert property (@(posedge clk) disable iff (rst)
    (slotValid && benign && !stopMark && !brTaken && !brkB && !rsvdB && !(rsvdPredB && predVal))
      |-> !groupEnd);

  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> (pendMask == '0));

  p_idle_slot_r10: assert property (@(posedge clk) disable iff (rst)
    !slotValid |=> (pendMask == $past(pendMask)));
endmodule

// File: rtl/igc_dpath.sv
module igc_dpath
  import igc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  strobe_t       st,
  input  logic          slotValid,
  input  logic [IW-1:0] wrIdx,
  input  logic [DW-1:0] wrData,
  input  logic [IW-1:0] rdIdxA,
  input  logic [IW-1:0] rdIdxB,
  output logic [DW-1:0] rdDataA,
  output logic [DW-1:0] rdDataB,
  input  logic          memWrEn,
  input  logic [AW-1:0] memWrAddr,
  input  logic [DW-1:0] memWrData,
  input  logic [AW-1:0] memRdAddr,
  output logic [DW-1:0] memRdData
);
  logic [DW-1:0] archReg [NREG];
  logic [DW-1:0] shadowReg [NREG];
  logic [DW-1:0] scratch [MWORDS];

  assign rdDataA   = archReg[rdIdxA];
  assign rdDataB   = archReg[rdIdxB];
  assign memRdData = scratch[memRdAddr];

  always_ff @(posedge clk) begin
    if (st.bufWr) shadowReg[wrIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) archReg[i] <= '0;
    end else if (st.commit) begin
      for (int i = 0; i < NREG; i++) begin
        if (st.bufWr && wrIdx == IW'(i)) archReg[i] <= wrData;
        else if (st.pendMask[i])         archReg[i] <= shadowReg[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < MWORDS; j++) scratch[j] <= '0;
    end else if (slotValid && memWrEn) begin
      scratch[memWrAddr] <= memWrData;
    end
  end

  p_store_visible_r8: assert property (@(posedge clk) disable iff (rst)
    (slotValid && memWrEn) |=> (scratch[$past(memWrAddr)] == $past(memWrData)));

  p_hold_in_group_r5: assert property (@(posedge clk) disable iff (rst)
    (!st.commit ##1 $stable(rdIdxA)) |-> $stable(rdDataA));
endmodule

// File: rtl/igroup_commit.sv
module igroup_commit
  import igc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          slotValid,
  input  logic          stopMark,
  input  logic          brTaken,
  input  logic          brkB,
  input  logic          rsvdB,
  input  logic          rsvdPredB,
  input  logic          predVal,
  input  logic          otherBrk,
  input  logic          chkInst,
  input  logic          rfiInst,
  input  logic          brlInst,
  input  logic          wrEn,
  input  logic [IW-1:0] wrIdx,
  input  logic [DW-1:0] wrData,
  input  logic [IW-1:0] rdIdxA,
  input  logic [IW-1:0] rdIdxB,
  output logic [DW-1:0] rdDataA,
  output logic [DW-1:0] rdDataB,
  input  logic          memWrEn,
  input  logic [AW-1:0] memWrAddr,
  input  logic [DW-1:0] memWrData,
  input  logic [AW-1:0] memRdAddr,
  output logic [DW-1:0] memRdData,
  output logic          groupEnd,
  output logic          depViol
);
  strobe_t st;

  igc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .slotValid(slotValid), .stopMark(stopMark),
    .brTaken(brTaken), .brkB(brkB), .rsvdB(rsvdB), .rsvdPredB(rsvdPredB),
    .predVal(predVal), .otherBrk(otherBrk), .chkInst(chkInst),
    .rfiInst(rfiInst), .brlInst(brlInst), .wrEn(wrEn), .wrIdx(wrIdx),
    .st(st), .groupEnd(groupEnd), .depViol(depViol)
  );

  igc_dpath u_dpath (
    .clk(clk), .rst(rst), .st(st), .slotValid(slotValid),
    .wrIdx(wrIdx), .wrData(wrData), .rdIdxA(rdIdxA), .rdIdxB(rdIdxB),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .memRdAddr(memRdAddr),
    .memRdData(memRdData)
  );
endmodule

// File: tb/sim_igroup_commit.sv
`timescale 1ns/1ps
module sim_igroup_commit;
  import igc_pkg::*;

  logic clk = 0, rst = 1;
  logic slotValid, stopMark, brTaken, brkB, rsvdB, rsvdPredB, predVal;
  logic otherBrk, chkInst, rfiInst, brlInst, wrEn, memWrEn;
  logic [IW-1:0] wrIdx, rdIdxA, rdIdxB;
  logic [AW-1:0] memWrAddr, memRdAddr;
  logic [DW-1:0] wrData, memWrData, rdDataA, rdDataB, memRdData;
  logic groupEnd, depViol;

  always #2.5 clk = ~clk;

  igroup_commit u0 (.*);

  typedef struct {
    logic v, stop, br, brkb, rsv, rsvp, pred, oth, chk, rfi, brl, wr, mw;
    logic [IW-1:0] idx, ra, rb;
    logic [DW-1:0] d, md;
    logic [AW-1:0] ma, mra;
  } slot_t;

  typedef struct {
    logic ge, dv;
    logic [DW-1:0] a, b, m;
    string tag;
  } exp_t;

  exp_t expQ[$];
  int checks = 0, errors = 0;
  logic [DW-1:0] archM [NREG];
  logic [DW-1:0] shadM [NREG];
  logic [NREG-1:0] pendM;
  logic [DW-1:0] memM [MWORDS];

  function automatic slot_t blank();
    slot_t s;
    s = '{default: '0};
    s.v = 1;
    return s;
  endfunction

  task automatic clearModel();
    for (int i = 0; i < NREG; i++) begin archM[i] = '0; shadM[i] = '0; end
    for (int j = 0; j < MWORDS; j++) memM[j] = '0;
    pendM = '0;
  endtask

  task automatic drive(input slot_t s, input string tag);
    exp_t e;
    logic close;
    @(posedge clk); #1;
    slotValid = s.v; stopMark = s.stop; brTaken = s.br; brkB = s.brkb;
    rsvdB = s.rsv; rsvdPredB = s.rsvp; predVal = s.pred; otherBrk = s.oth;
    chkInst = s.chk; rfiInst = s.rfi; brlInst = s.brl; wrEn = s.wr;
    wrIdx = s.idx; wrData = s.d; rdIdxA = s.ra; rdIdxB = s.rb;
    memWrEn = s.mw; memWrAddr = s.ma; memWrData = s.md; memRdAddr = s.mra;
    close = s.v & (s.stop | s.br | s.brkb | s.rsv | (s.rsvp & s.pred));
    e.ge = close;
    e.dv = s.v & s.wr & pendM[s.idx];
    e.a = archM[s.ra]; e.b = archM[s.rb]; e.m = memM[s.mra];
    e.tag = tag;
    expQ.push_back(e);
    if (s.v && s.wr) begin shadM[s.idx] = s.d; pendM[s.idx] = 1'b1; end
    if (close) begin
      for (int i = 0; i < NREG; i++) if (pendM[i]) archM[i] = shadM[i];
      pendM = '0;
    end
    if (s.v && s.mw) memM[s.ma] = s.md;
  endtask

  task automatic cmp(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per driven slot
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      cmp(e.tag, "groupEnd", DW'(groupEnd), DW'(e.ge));
      cmp(e.tag, "depViol", DW'(depViol), DW'(e.dv));
      cmp(e.tag, "rdDataA", rdDataA, e.a);
      cmp(e.tag, "rdDataB", rdDataB, e.b);
      cmp(e.tag, "memRdData", memRdData, e.m);
    end
  end

  task automatic doReset();
    @(posedge clk); #1;
    rst = 1; slotValid = 0; wrEn = 0; memWrEn = 0;
    clearModel();
    @(posedge clk); #1;
    rst = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    slot_t s;
    slotValid = 0; stopMark = 0; brTaken = 0; brkB = 0; rsvdB = 0; rsvdPredB = 0;
    predVal = 0; otherBrk = 0; chkInst = 0; rfiInst = 0; brlInst = 0; wrEn = 0;
    wrIdx = 0; wrData = 0; rdIdxA = 0; rdIdxB = 0; memWrEn = 0; memWrAddr = 0;
    memWrData = 0; memRdAddr = 0;
    clearModel();
    repeat (2) @(posedge clk);
    #1 rst = 0;

    // reset state, idle slot (R9, R10)
    s = blank(); s.v = 0; s.ra = 1; s.rb = 31; drive(s, "R9_reset_state");

    // R5 / R1 / R6: write r1, read before and after the stop
    s = blank(); s.wr = 1; s.idx = 1; s.d = 64'h11; s.ra = 1; drive(s, "R5_same_slot");
    s = blank(); s.ra = 1; s.rb = 1; drive(s, "R5_later_slot");
    s = blank(); s.stop = 1; s.wr = 1; s.idx = 2; s.d = 64'h22; s.ra = 2; drive(s, "R1_stop");
    s = blank(); s.ra = 1; s.rb = 2; drive(s, "R6_after_stop");

    // R2 taken branch closes
    s = blank(); s.br = 1; s.wr = 1; s.idx = 4; s.d = 64'h44; drive(s, "R2_branch");
    s = blank(); s.ra = 4; s.stop = 1; drive(s, "R2_visible");

    // R3 fault kinds
    s = blank(); s.brkb = 1; s.wr = 1; s.idx = 5; s.d = 64'h55; drive(s, "R3_brkb");
    s = blank(); s.ra = 5; s.rsv = 1; s.wr = 1; s.idx = 6; s.d = 64'h66; drive(s, "R3_rsvd");
    s = blank(); s.ra = 6; s.rsvp = 1; s.pred = 0; s.wr = 1; s.idx = 7; s.d = 64'h77; drive(s, "R3_rsvp_pred0");
    s = blank(); s.ra = 7; s.rsvp = 1; s.pred = 1; drive(s, "R3_rsvp_pred1");
    s = blank(); s.ra = 7; drive(s, "R3_rsvp_visible");

    // R4 benign flags do not close
    s = blank(); s.oth = 1; s.wr = 1; s.idx = 8; s.d = 64'h88; drive(s, "R4_otherbrk");
    s = blank(); s.chk = 1; s.ra = 8; drive(s, "R4_check");
    s = blank(); s.rfi = 1; s.ra = 8; drive(s, "R4_rfi");
    s = blank(); s.brl = 1; s.ra = 8; s.oth = 1; s.chk = 1; drive(s, "R4_brl");
    s = blank(); s.stop = 1; s.ra = 8; drive(s, "R4_close");
    s = blank(); s.ra = 8; drive(s, "R4_visible");

    // R7 double write
    s = blank(); s.wr = 1; s.idx = 9; s.d = 64'hA1; drive(s, "R7_first");
    s = blank(); s.wr = 1; s.idx = 9; s.d = 64'hA2; s.ra = 9; drive(s, "R7_second");
    s = blank(); s.stop = 1; s.wr = 1; s.idx = 10; s.d = 64'hB0; drive(s, "R7_close");
    s = blank(); s.ra = 9; s.rb = 10; drive(s, "R7_later_wins");

    // R8 scratch store visible inside the group
    s = blank(); s.mw = 1; s.ma = 3; s.md = 64'h3333; s.mra = 3; drive(s, "R8_store");
    s = blank(); s.mra = 3; drive(s, "R8_load");
    s = blank(); s.mw = 1; s.ma = 15; s.md = 64'hFFFF; s.mra = 3; drive(s, "R8_store_top");
    s = blank(); s.mra = 15; s.stop = 1; drive(s, "R8_load_top");

    // R10 invalid slot has no effect
    s = blank(); s.v = 0; s.stop = 1; s.wr = 1; s.idx = 11; s.d = 64'hDEAD;
    s.mw = 1; s.ma = 4; s.md = 64'hBEEF; drive(s, "R10_invalid");
    s = blank(); s.stop = 1; s.ra = 11; s.mra = 4; drive(s, "R10_close");
    s = blank(); s.ra = 11; s.rb = 9; s.mra = 4; drive(s, "R10_no_write");

    // R9 reset mid-group
    s = blank(); s.wr = 1; s.idx = 12; s.d = 64'hC0; drive(s, "R9_pending");
    doReset();
    s = blank(); s.stop = 1; s.ra = 12; s.rb = 1; s.mra = 3; drive(s, "R9_after_reset");
    s = blank(); s.ra = 12; s.rb = 9; s.mra = 15; drive(s, "R9_dropped");

    @(posedge clk); @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule